// File: doc/BRIEF.md
# Bus-Kicked Watchdog and Reset Supervisor

This block is the reset-generation core of a CPU supervisor. It watches the two lines of a two-wire serial bus. It also takes a low-supply flag that is already synchronized, an active-low power-on indication and a 2-bit watchdog period select. From these it drives one reset output. A parameter sets whether that output is active-low or active-high. There is no dedicated kick pin. Software keeps the watchdog alive by making a start-like event on the bus: the data line falls while the clock line is high.

Three causes assert reset: power-up, low supply and watchdog expiry. All three release through the same hold stretch of `HOLD_TICKS` prescaler ticks. A shared tick timer module measures both the hold stretch and the watchdog period. Each timer is paced by a clock-enable prescaler of `TICK_DIV` cycles, so a simulation can use short values.

A state machine has three states:
- `ST_HOLD`: reset is active and the hold timer runs.
- `ST_LOWV`: reset is active and the block waits for the supply flag to clear.
- `ST_RUN`: reset is released and the watchdog timer runs.

The transitions are:
- **power-on entry**: to `ST_HOLD` while `por_n` is low.
- **supply drop**: from any state to `ST_LOWV` when `low_vcc` is high.
- **supply recovered**: from `ST_LOWV` to `ST_HOLD` when `low_vcc` is low.
- **hold elapsed**: from `ST_HOLD` to `ST_RUN` when the hold timer is done.
- **watchdog expiry**: from `ST_RUN` to `ST_HOLD` when the watchdog timer is done.

Top module: `bus_wdt_supervisor`

## Requirements
- R1: While `por_n` is low, the reset output is active, and the block restarts in `ST_HOLD`.
- R2: After `por_n` rises, reset stays active for `HOLD_TICKS*TICK_DIV+1` clock cycles and is then released.
- R3: `wd_sel` picks the watchdog period: 2'b00 gives `WD_TICKS_0`, 2'b01 gives `WD_TICKS_1` and 2'b10 gives `WD_TICKS_2` ticks of `TICK_DIV` cycles. Without a kick, reset reasserts `period*TICK_DIV+1` cycles after it was released.
- R4: A kick restarts the watchdog count. A kick is a high-to-low change of the synchronized SDA in a cycle where the synchronized SCL is high. It takes effect three cycles after the SDA pin falls. Kicks spaced closer than the period keep reset released.
- R5: An SDA fall while SCL is low does not restart the watchdog. The expiry time stays as if no such edge occurred.
- R6: When `low_vcc` is high at a clock edge, reset is active from that edge, in any state.
- R7: When `low_vcc` clears, a full hold stretch starts over. A pulse of `low_vcc` during a hold restarts the stretch.
- R8: After a watchdog expiry, reset is held for the same `HOLD_TICKS*TICK_DIV+1` cycles and is then released.
- R9: While reset is active, the watchdog count is held at zero. The watchdog period is counted from the cycle in which reset is released.
- R10: With `RST_ACTIVE_HIGH=0`, active reset drives `rst_out` to 0. With `RST_ACTIVE_HIGH=1`, active reset drives it to 1.
- R11: `wd_sel`=2'b11 disables the watchdog, so it never expires. On a later switch to a period, counting starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on indication; low means power is not yet good (asynchronous) |
| low_vcc | input | 1 | Synchronized low-supply comparator flag, active high |
| sda | input | 1 | Two-wire bus data line (raw pin level) |
| scl | input | 1 | Two-wire bus clock line (raw pin level) |
| wd_sel | input | 2 | Watchdog period select; 2'b11 turns the watchdog off |
| rst_out | output | 1 | Reset output; its polarity is set by `RST_ACTIVE_HIGH` |

## Verification
Each of the three periods is first left to expire with no bus activity at all. This separates the select decode and the shared hold stretch from the kick logic. A directed kick is compared with a false edge, where SDA falls while SCL is low. The two differ only in the expiry time, so a detector that ignores SCL stands out.

A seeded random run sends kicks at random spacings just under a period that changes at random. This shows that every kick clears the count regardless of its phase against the prescaler. Supply drops, a pulse during the hold, the disabled select and a power-on in the middle of the run cover the remaining transitions. A second instance with the opposite polarity is compared against the first.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOWV = 2'd1,
        ST_RUN  = 2'd2
    } sup_state_e;

    localparam logic [1:0] WD_SEL_OFF = 2'b11;

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/sup_bus_kick.sv
module sup_bus_kick (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic kick
);

    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_s;
    end

    assign kick = sda_prev & ~sda_s & scl_s;

    // R4
    kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick);

endmodule

// File: rtl/sup_tick_timer.sv
module sup_tick_timer #(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0]    pre_q;
    logic [CNT_W-1:0] ticks_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (clr) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick && (ticks_q < limit)) ticks_q <= ticks_q + 1'b1;
        end
    end

    assign done = (ticks_q >= limit);

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ticks_q == '0 && pre_q == '0));

endmodule

// File: rtl/bus_wdt_supervisor.sv
module bus_wdt_supervisor
    import sup_pkg::*;
#(
    parameter int TICK_DIV        = 125000,
    parameter int HOLD_TICKS      = 250,
    parameter int WD_TICKS_0      = 1400,
    parameter int WD_TICKS_1      = 600,
    parameter int WD_TICKS_2      = 200,
    parameter bit RST_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       low_vcc,
    input  logic       sda,
    input  logic       scl,
    input  logic [1:0] wd_sel,
    output logic       rst_out
);

    localparam int MAX_A  = (WD_TICKS_0 > WD_TICKS_1) ? WD_TICKS_0 : WD_TICKS_1;
    localparam int MAX_B  = (WD_TICKS_2 > HOLD_TICKS) ? WD_TICKS_2 : HOLD_TICKS;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_T + 2);

    sup_state_e       state_q, state_d;
    logic             rst_q;
    logic [1:0]       bus_s;
    logic             kick;
    logic             hold_done, wd_done;
    logic             hold_clr, wd_clr;
    logic [CNT_W-1:0] wd_limit;

    // Bus line synchronizers, idle level high
    sup_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({sda, scl}),
        .q     (bus_s)
    );

    sup_bus_kick u_kick (
        .clk   (clk),
        .rst_n (por_n),
        .sda_s (bus_s[1]),
        .scl_s (bus_s[0]),
        .kick  (kick)
    );

    // Period decode
    always_comb begin
        unique case (wd_sel)
            2'b00:   wd_limit = CNT_W'(WD_TICKS_0);
            2'b01:   wd_limit = CNT_W'(WD_TICKS_1);
            2'b10:   wd_limit = CNT_W'(WD_TICKS_2);
            default: wd_limit = '1;
        endcase
    end

    assign hold_clr = (state_q != ST_HOLD);
    assign wd_clr   = (state_q != ST_RUN) || kick || (wd_sel == WD_SEL_OFF);

    sup_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_hold_tmr (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (hold_clr),
        .limit (CNT_W'(HOLD_TICKS)),
        .done  (hold_done)
    );

    sup_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_wd_tmr (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (wd_clr),
        .limit (wd_limit),
        .done  (wd_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (low_vcc)        state_d = ST_LOWV;
                else if (hold_done) state_d = ST_RUN;
            end
            ST_LOWV: begin
                if (!low_vcc)       state_d = ST_HOLD;
            end
            ST_RUN: begin
                if (low_vcc)        state_d = ST_LOWV;
                else if (wd_done)   state_d = ST_HOLD;
            end
            default:                state_d = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rst_q <= 1'b1;
        else        rst_q <= (state_d != ST_RUN);
    end

    generate
        if (RST_ACTIVE_HIGH) begin : g_pol_high
            assign rst_out = rst_q;
        end else begin : g_pol_low
            assign rst_out = ~rst_q;
        end
    endgenerate

    // R6
    low_supply_chk: assert property (@(posedge clk) disable iff (!por_n)
        low_vcc |=> (state_q == ST_LOWV && rst_q));

    // R7
    lowv_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_LOWV && !low_vcc) |=> (state_q == ST_HOLD));

    // R2
    hold_min_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD && !hold_done) |=> (state_q != ST_RUN));

    // R8
    wd_expire_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN && !low_vcc && wd_done) |=> (state_q == ST_HOLD && rst_q));

    // R11
    wd_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wd_sel == WD_SEL_OFF && $past(wd_sel) == WD_SEL_OFF) |-> !wd_done);

endmodule

// File: tb/bus_wdt_supervisor_bench.sv
`timescale 1ns/1ps
module bus_wdt_supervisor_bench;

    localparam int DIV  = 4;
    localparam int HOLD = 10;
    localparam int T0   = 40;
    localparam int T1   = 25;
    localparam int T2   = 12;
    localparam int HC   = HOLD * DIV + 1;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       low_vcc = 1'b0;
    logic       sda = 1'b1;
    logic       scl = 1'b1;
    logic [1:0] wd_sel = 2'b00;
    logic       rst_lo, rst_hi;
    logic       rst_act;
    int         checks = 0;
    int         fails = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    bus_wdt_supervisor #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD), .WD_TICKS_0(T0),
        .WD_TICKS_1(T1), .WD_TICKS_2(T2), .RST_ACTIVE_HIGH(1'b0)) u_bus_wdt_supervisor (
        .clk(clk), .por_n(por_n), .low_vcc(low_vcc), .sda(sda), .scl(scl),
        .wd_sel(wd_sel), .rst_out(rst_lo));

    bus_wdt_supervisor #(.TICK_DIV(DIV), .HOLD_TICKS(HOLD), .WD_TICKS_0(T0),
        .WD_TICKS_1(T1), .WD_TICKS_2(T2), .RST_ACTIVE_HIGH(1'b1)) u_bus_wdt_supervisor_hi (
        .clk(clk), .por_n(por_n), .low_vcc(low_vcc), .sda(sda), .scl(scl),
        .wd_sel(wd_sel), .rst_out(rst_hi));

    assign rst_act = ~rst_lo;

    function automatic int period_cyc(logic [1:0] s);
        case (s)
            2'b00:   return T0 * DIV;
            2'b01:   return T1 * DIV;
            2'b10:   return T2 * DIV;
            default: return 0;
        endcase
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_rst(bit expv, string req, string what);
        check(rst_act == expv, req, what, int'(rst_act), int'(expv));
    endtask

    task automatic hold_window(int d, string req);
        step(d - 2);
        expect_rst(1'b1, req, "reset held before release");
        step(3);
        expect_rst(1'b0, req, "reset released after hold");
    endtask

    task automatic expire_window(int d, string req);
        step(d - 2);
        expect_rst(1'b0, req, "reset idle before expiry");
        step(3);
        expect_rst(1'b1, req, "reset after expiry");
    endtask

    task automatic kick();
        sda = 1'b0;
        step(4);
        sda = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int gap;
        bit bad;
        void'($urandom(32'd4283));

        // R1 / R10: reset state
        step(5);
        expect_rst(1'b1, "R1", "reset during power-on");
        check(rst_lo == 1'b0 && rst_hi == 1'b1, "R10", "active polarity lo/hi",
              int'({rst_lo, rst_hi}), 1);

        // R2: power-up hold
        por_n = 1'b1;
        hold_window(HC, "R2");
        check(rst_lo == 1'b1 && rst_hi == 1'b0, "R10", "idle polarity lo/hi",
              int'({rst_lo, rst_hi}), 2);

        // R3 / R9: period 0 counted from release, then R8 shared hold
        expire_window(period_cyc(2'b00), "R3");
        hold_window(HC - 1, "R8");
        wd_sel = 2'b01;
        expire_window(period_cyc(2'b01), "R3");
        hold_window(HC - 1, "R8");
        wd_sel = 2'b10;
        expire_window(period_cyc(2'b10), "R3");
        hold_window(HC - 1, "R8");

        // R5: SDA falls while SCL is low, no restart
        wd_sel = 2'b00;
        step(19);
        scl = 1'b0; step(2);
        sda = 1'b0; step(4);
        scl = 1'b1; step(2);
        sda = 1'b1; step(2);
        expire_window(period_cyc(2'b00) - 29, "R5");
        hold_window(HC - 1, "R8");

        // R4: directed kick moves the expiry
        step(30);
        kick();
        expire_window(period_cyc(2'b00), "R4");
        hold_window(HC - 1, "R8");

        // R4: random kick spacing and random period
        for (int i = 0; i < 40; i++) begin
            kick();
            wd_sel = 2'($urandom_range(0, 2));
            gap = $urandom_range(2, period_cyc(wd_sel) - 12);
            bad = 1'b0;
            for (int j = 0; j < gap; j++) begin
                step(1);
                if (rst_act) bad = 1'b1;
            end
            check(!bad, "R4", "reset stayed released under kicks", int'(bad), 0);
        end

        // R11: disabled select
        kick();
        wd_sel = 2'b11;
        bad = 1'b0;
        for (int j = 0; j < 3 * period_cyc(2'b00); j++) begin
            step(1);
            if (rst_act) bad = 1'b1;
        end
        check(!bad, "R11", "no expiry while disabled", int'(bad), 0);
        wd_sel = 2'b00;
        expire_window(period_cyc(2'b00) + 1, "R11");
        hold_window(HC - 1, "R8");

        // R6 / R7: supply drop in run state
        step(10);
        low_vcc = 1'b1;
        step(1);
        expect_rst(1'b1, "R6", "reset on low supply");
        step(20);
        expect_rst(1'b1, "R6", "reset while supply low");
        low_vcc = 1'b0;
        hold_window(HC + 1, "R7");

        // R7: pulse during hold restarts the stretch
        step(5);
        low_vcc = 1'b1;
        step(1);
        low_vcc = 1'b0;
        step(20);
        low_vcc = 1'b1;
        step(1);
        low_vcc = 1'b0;
        step(22);
        expect_rst(1'b1, "R7", "hold restarted by pulse");
        hold_window(20, "R7");

        // R1: power-on again in the middle of the run
        por_n = 1'b0;
        step(1);
        expect_rst(1'b1, "R1", "reset on power-on mid-run");
        check(rst_hi == 1'b1, "R10", "active-high instance active", int'(rst_hi), 1);
        por_n = 1'b1;
        hold_window(HC, "R2");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule